// File: doc/BRIEF.md
# GPIO Port with Both-Edge Change Interrupts

This block is a general-purpose I/O port of up to 32 lines, driven from a 32-bit register bus. Software picks each line's direction and output value. It reads the live level of every line and watches each line for activity. Every line feeds a two-flop synchroniser and a transition detector. The detector reacts to both rising and falling edges and records each one in a sticky change flag. Software acknowledges a flag by writing a one to it.

A per-line enable register gates the flags onto one combined interrupt output. Flags collect transitions even while their line is masked. A data write only touches the bits that a separate write-mask register allows, so one driver can update some lines without a read-modify-write. A read-only trigger register reports that every implemented line triggers on both edges.

The bus is word-addressed: registers sit on 4-byte boundaries of a 5-bit byte address. Reads are combinational in the cycle the read strobe is high. Writes take effect at the clock edge that samples the strobe.

Top module: `gpio_edge_port`

## Requirements
- R1: After a synchronous active-low reset, direction, output data, enable and change flags are all zero, pin_oe is zero, irq is low, and the write-mask register (byte offset 0x10) reads as all ones over the implemented lines.
- R2: Writing the direction register (offset 0x00) sets pin_oe to the written bits, with 1 meaning output and 0 meaning input, and the register reads back the same value.
- R3: A write to the data register (offset 0x04) changes only those pin_out bits whose write-mask bit (offset 0x10) is 1. The other output bits keep their value.
- R4: Reading the data register returns, per bit, the output data bit for lines set as outputs and the synchronised pin_in level for lines set as inputs.
- R5: Every rising and every falling transition of pin_in sets that line's change flag (offset 0x0C). The flag first reads as 1 after the third rising clock edge following the pin change, and not after the second.
- R6: Writing 1 to a change-flag bit clears it and writing 0 leaves it unchanged. A transition whose detection lands in the same cycle as the clear leaves the flag set.
- R7: irq is the OR over all lines of (change flag AND enable bit, offset 0x08). A flag set while its line is masked raises irq as soon as the enable bit is written.
- R8: The trigger register (offset 0x14) reads as all ones over the implemented lines, meaning both-edge triggering, and writes to it are ignored.
- R9: Bits above the implemented line count read as zero. Offsets 0x18 and 0x1C read as zero. An access whose two low address bits are not zero reads as zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is strobed |
| pin_in | input | LINES | Pad input levels, asynchronous |
| pin_out | output | LINES | Output data toward the pads |
| pin_oe | output | LINES | Output enable per line (1 = drive) |
| irq | output | 1 | Combined change interrupt |

## Verification
The synchroniser flops carry no reset. The edge-quiet assertion therefore assumes reset is held for at least three clock cycles, which lets the chain settle before flags leave reset. The bench holds reset for five cycles with all pins low. The assertions also treat pin_in as changing away from the sampling edge. The bench changes pins and bus signals only on falling clock edges, and it places each transition and each clear so that the collision case falls on one chosen rising edge.

// File: rtl/gep_pkg.sv
// Package: shared constants and the register-select encoding for the GPIO port.
// Assumes a 32-bit bus data path and word-aligned registers in a 5-bit byte space.
package gep_pkg;
    localparam int BUS_ADDR_W = 5;
    localparam int BUS_DATA_W = 32;
    localparam int SEL_W      = BUS_ADDR_W - 2;

    // Word index of each register (byte offset / 4)
    typedef enum logic [SEL_W-1:0] {
        SEL_DIR    = 3'd0,
        SEL_DATA   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_CHANGE = 3'd3,
        SEL_WMASK  = 3'd4,
        SEL_TRIG   = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gep_sync.sv
// Module: input synchroniser plus transition detector for every line.
// Each pin passes through SYNC_STAGES flops. The last stage is compared with
// its value one cycle earlier, so any change in either direction gives a
// one-cycle pulse. The flops have no reset on purpose. Assumes reset is held
// long enough (SYNC_STAGES+1 cycles) that the chain has settled when flags start.
module gep_sync #(
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] line_lvl,
    output logic [LINES-1:0] edge_det
);
    logic [LINES-1:0] chain [SYNC_STAGES];
    logic [LINES-1:0] lvl_prev;

    // Shift the pads through the synchroniser chain
    always_ff @(posedge clk) begin
        chain[0] <= pin_in;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            chain[s] <= chain[s-1];
        end
    end

    // Remember the synchronised level from the previous cycle
    always_ff @(posedge clk) begin
        lvl_prev <= chain[SYNC_STAGES-1];
    end

    // Both-edge detection: any difference from last cycle is a transition
    always_comb begin
        line_lvl = chain[SYNC_STAGES-1];
        edge_det = line_lvl ^ lvl_prev;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_chk2
            // R5: a pin steady over the last three samples produces no edge
            a_r5_quiet_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
                (($past(pin_in, 1) == pin_in) && ($past(pin_in, 2) == pin_in) &&
                 ($past(pin_in, 3) == pin_in)) |-> (edge_det == '0));
        end
    endgenerate
endmodule

// File: rtl/gep_change.sv
// Module: sticky change flags and the combined interrupt.
// A detected transition sets its flag. A clear pulse drops a flag only when no
// transition arrives in the same cycle, so the transition is never lost.
// Assumes clr_pulse is a single-cycle write strobe from the register file.
module gep_change #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] edge_det,
    input  logic [LINES-1:0] clr_pulse,
    input  logic [LINES-1:0] en_q,
    output logic [LINES-1:0] flags,
    output logic             irq
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            // Per-line flag: a new edge wins over a same-cycle acknowledge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags[g] <= 1'b0;
                end else begin
                    flags[g] <= edge_det[g] | (flags[g] & ~clr_pulse[g]);
                end
            end
        end
    endgenerate

    // Combine enabled flags into the single interrupt line
    always_comb begin
        irq = |(flags & en_q);
    end

    // R6: every detected edge is visible as a set flag on the next cycle
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det != '0) |=> ((flags & $past(edge_det)) == $past(edge_det)));

    // R6: with no acknowledge, no flag ever drops
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse == '0) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/gep_regfile.sv
// Module: register file and read multiplexer of the GPIO port.
// Holds direction, output data, enable and write-mask state. It turns writes to
// the change register into an acknowledge pulse and answers reads
// combinationally. Assumes word-aligned accesses; misaligned ones are dropped.
module gep_regfile
    import gep_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]      line_lvl,
    input  logic [LINES-1:0]      flags,
    output logic [LINES-1:0]      dir_q,
    output logic [LINES-1:0]      out_q,
    output logic [LINES-1:0]      en_q,
    output logic [LINES-1:0]      clr_pulse
);
    localparam logic [LINES-1:0] ALL_ONES = {LINES{1'b1}};

    logic             aligned;
    logic [SEL_W-1:0] idx;
    logic [LINES-1:0] wd;
    logic [LINES-1:0] wmask_q;
    logic [LINES-1:0] rd_line;
    logic             wr_dir, wr_data, wr_en, wr_chg, wr_mask;

    // Decode the access into per-register write strobes
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        idx     = bus_addr[BUS_ADDR_W-1:2];
        wd      = bus_wdata[LINES-1:0];
        wr_dir  = bus_sel & bus_wr & aligned & (idx == SEL_DIR);
        wr_data = bus_sel & bus_wr & aligned & (idx == SEL_DATA);
        wr_en   = bus_sel & bus_wr & aligned & (idx == SEL_ENABLE);
        wr_chg  = bus_sel & bus_wr & aligned & (idx == SEL_CHANGE);
        wr_mask = bus_sel & bus_wr & aligned & (idx == SEL_WMASK);
    end

    // Direction register
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wd;
    end

    // Output data register, updated only in bits the write mask allows
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (wr_data) out_q <= (out_q & ~wmask_q) | (wd & wmask_q);
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wd;
    end

    // Write-mask register, all lines writable after reset
    always_ff @(posedge clk) begin
        if (!rst_n)       wmask_q <= ALL_ONES;
        else if (wr_mask) wmask_q <= wd;
    end

    // Acknowledge pulse toward the change flags
    always_comb begin
        clr_pulse = wr_chg ? wd : '0;
    end

    // Read multiplexer; unused offsets and unimplemented bits read zero
    always_comb begin
        case (idx)
            SEL_DIR:    rd_line = dir_q;
            SEL_DATA:   rd_line = (dir_q & out_q) | (~dir_q & line_lvl);
            SEL_ENABLE: rd_line = en_q;
            SEL_CHANGE: rd_line = flags;
            SEL_WMASK:  rd_line = wmask_q;
            SEL_TRIG:   rd_line = ALL_ONES;
            default:    rd_line = '0;
        endcase
        bus_rdata = (bus_sel & ~bus_wr & aligned) ? BUS_DATA_W'(rd_line) : '0;
    end

    // R2: a direction write is what the register holds on the next cycle
    a_r2_dir_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(wd)));

    // R3: a data write with an all-zero mask leaves the outputs alone
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && (wmask_q == '0)) |=> $stable(out_q));
endmodule

// File: rtl/gpio_edge_port.sv
// Module: top of the GPIO port with both-edge change interrupts.
// Connects the register file, the input synchronisers and the change flags,
// and drives the pad-side output and enable vectors. Assumes LINES <= 32 and a
// single clock domain for the bus; pin_in may be asynchronous.
module gpio_edge_port
    import gep_pkg::*;
#(
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]      pin_in,
    output logic [LINES-1:0]      pin_out,
    output logic [LINES-1:0]      pin_oe,
    output logic                  irq
);
    logic [LINES-1:0] line_lvl, edge_det, flags;
    logic [LINES-1:0] dir_q, out_q, en_q, clr_pulse;

    gep_sync #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .line_lvl (line_lvl),
        .edge_det (edge_det)
    );

    gep_regfile #(.LINES(LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .line_lvl  (line_lvl),
        .flags     (flags),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .en_q      (en_q),
        .clr_pulse (clr_pulse)
    );

    gep_change #(.LINES(LINES)) u_change (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_det  (edge_det),
        .clr_pulse (clr_pulse),
        .en_q      (en_q),
        .flags     (flags),
        .irq       (irq)
    );

    // Pad-side drive straight from the direction and data registers
    always_comb begin
        pin_out = out_q;
        pin_oe  = dir_q;
    end

    // R7: no pending flag means no interrupt
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);

    // R7: a masked port never interrupts
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/gpio_edge_port_bench.sv
// Directed bench for gpio_edge_port, built with 12 lines so that the
// unimplemented upper bits are visible. Inputs change on falling edges only.
module gpio_edge_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL         = 12;
    localparam logic [31:0] IMPL = 32'h0000_0FFF;

    localparam logic [4:0] A_DIR  = 5'h00;
    localparam logic [4:0] A_DATA = 5'h04;
    localparam logic [4:0] A_EN   = 5'h08;
    localparam logic [4:0] A_CHG  = 5'h0C;
    localparam logic [4:0] A_MASK = 5'h10;
    localparam logic [4:0] A_TRIG = 5'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;

    gpio_edge_port #(.LINES(NL)) u_gpio_edge_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Caller stands at a falling edge; the write lands on the next rising edge
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 dir", A_DIR, 32'h0);
        expect_reg("R1 enable", A_EN, 32'h0);
        expect_reg("R1 change", A_CHG, 32'h0);
        expect_reg("R1 mask", A_MASK, IMPL);
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_direction;
        bus_write(A_DIR, 32'h0000_0A5A);
        check("R2 pin_oe", 32'(pin_oe), 32'h0A5A);
        expect_reg("R2 readback", A_DIR, 32'h0A5A);
    endtask

    task automatic t_write_mask;
        bus_write(A_DATA, 32'h0000_0FFF);
        check("R3 full mask", 32'(pin_out), 32'h0FFF);
        bus_write(A_MASK, 32'h0000_000F);
        expect_reg("R3 mask readback", A_MASK, 32'h000F);
        bus_write(A_DATA, 32'h0);
        check("R3 partial mask", 32'(pin_out), 32'h0FF0);
        bus_write(A_MASK, IMPL);
    endtask

    task automatic t_data_read;
        logic [31:0] exp;
        pin_in = 12'h3C3;
        tick(4);
        exp = ((32'h0A5A & 32'h0FF0) | (~32'h0A5A & 32'h03C3)) & IMPL;
        expect_reg("R4 mixed read", A_DATA, exp);
        bus_write(A_DIR, 32'h0);
        expect_reg("R4 all inputs", A_DATA, 32'h03C3);
        bus_write(A_CHG, IMPL);
        expect_reg("R4 flags cleared", A_CHG, 32'h0);
    endtask

    task automatic t_edges;
        pin_in[0] = 1'b0;                 // falling edge on line 0
        tick(2);
        expect_reg("R5 fall not yet", A_CHG, 32'h0);
        tick(1);
        expect_reg("R5 fall flagged", A_CHG, 32'h001);
        bus_write(A_CHG, 32'h001);
        pin_in[4] = 1'b1;                 // rising edge on line 4
        tick(2);
        expect_reg("R5 rise not yet", A_CHG, 32'h0);
        tick(1);
        expect_reg("R5 rise flagged", A_CHG, 32'h010);
        bus_write(A_CHG, 32'h010);
        expect_reg("R5 cleared", A_CHG, 32'h0);
    endtask

    task automatic t_clear;
        pin_in = pin_in ^ 12'h006;
        tick(4);
        expect_reg("R6 two set", A_CHG, 32'h006);
        bus_write(A_CHG, 32'h0);
        expect_reg("R6 write zero", A_CHG, 32'h006);
        bus_write(A_CHG, 32'h002);
        expect_reg("R6 one cleared", A_CHG, 32'h004);
        pin_in[2] = ~pin_in[2];           // detection lands on the 3rd rising edge
        tick(2);
        bus_write(A_CHG, 32'h004);        // acknowledge on that same edge
        expect_reg("R6 collision keeps", A_CHG, 32'h004);
        tick(2);
        bus_write(A_CHG, 32'h004);
        expect_reg("R6 later clear", A_CHG, 32'h0);
    endtask

    task automatic t_irq;
        pin_in[3] = ~pin_in[3];
        tick(4);
        expect_reg("R7 masked flag", A_CHG, 32'h008);
        check("R7 masked irq", 32'(irq), 32'h0);
        bus_write(A_EN, 32'h008);
        check("R7 enable raises", 32'(irq), 32'h1);
        bus_write(A_EN, 32'h0);
        check("R7 disable lowers", 32'(irq), 32'h0);
        bus_write(A_EN, 32'h100);
        check("R7 other line", 32'(irq), 32'h0);
        bus_write(A_EN, 32'h008);
        bus_write(A_CHG, 32'h008);
        check("R7 ack lowers", 32'(irq), 32'h0);
        bus_write(A_EN, 32'h0);
    endtask

    task automatic t_trig;
        expect_reg("R8 trig", A_TRIG, IMPL);
        bus_write(A_TRIG, 32'h0);
        expect_reg("R8 write ignored", A_TRIG, IMPL);
    endtask

    task automatic t_unimpl;
        bus_write(A_DIR, 32'hFFFF_FFFF);
        expect_reg("R9 upper bits zero", A_DIR, IMPL);
        expect_reg("R9 offset 0x18", 5'h18, 32'h0);
        expect_reg("R9 offset 0x1C", 5'h1C, 32'h0);
        expect_reg("R9 misaligned read", 5'h01, 32'h0);
        bus_write(5'h01, 32'h0);
        expect_reg("R9 misaligned write", A_DIR, IMPL);
        bus_write(A_DIR, 32'h0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_write_mask();
        t_data_read();
        t_edges();
        t_clear();
        t_irq();
        t_trig();
        t_unimpl();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule